// File: doc/BRIEF.md
# Byte-Lane Parity Guard with Sticky Error Capture

The block sits between a 32-bit memory data path and a memory array. On every write it computes one even-parity bit per byte lane and passes data, byte enables and parity bits to the array. On every read it recomputes parity over the returned data and compares it with the stored parity bits. It checks only the lanes that were actually read, and only while checking is enabled. A failed check records which lanes failed and the word address of the read in a status byte and an address register.

The record is sticky. Once an error is held, later errors do not change the lane flags or the address until a control write clears them. A test control bit stores deliberately inverted parity, so software can exercise the whole error path with a later read. An interrupt output is high while an error is held and the interrupt enable bit is set. The array returns read data exactly one cycle after the read request, and the block remembers the address and byte enables of the request for that check.

Top module: `mem_parity_guard`

## Requirements
- R1: With the test bit (status bit 5) clear, each write parity bit `arr_wpar_o[i]` is the XOR of the eight data bits of lane i, so the lane and its parity bit together hold an even number of ones. Lane i covers data bits 8i+7..8i.
- R2: With the test bit set, every write parity bit is inverted. A later checked read of a lane written this way flags that lane.
- R3: On a checked read, a parity mismatch in lane i sets status bit i (bit 3 for data 31..24, down to bit 0 for data 7..0). It also sets status bit 7 (error pending) and loads the read's address into `err_addr_o`. These changes are visible on the clock edge that ends the read-data cycle.
- R4: While status bit 4 (check enable) is clear, read mismatches are not recorded.
- R5: A lane whose byte enable was low on the read request never sets its status flag, even if its data and parity disagree.
- R6: While an error is held (bit 7 set) and no control write occurs, further mismatches change neither status bits 3..0 nor `err_addr_o`.
- R7: A control write loads status bits 6..4 from `reg_wdata_i[6:4]` and clears bits 7 and 3..0. It leaves `err_addr_o` unchanged.
- R8: If a mismatch is detected in the same cycle as a control write, the new error is recorded after the clear: its lane flags, bit 7 and its address take effect.
- R9: `irq_o` is high only while status bit 7 and status bit 6 (interrupt enable) are both set.
- R10: Reset clears the whole status byte, `err_addr_o` and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_wr_i | input | 1 | Write request from the data path |
| mem_rd_i | input | 1 | Read request from the data path (a write in the same cycle takes priority) |
| mem_addr_i | input | 16 | Access address |
| mem_be_i | input | 4 | Byte-lane enables |
| mem_wdata_i | input | 32 | Write data |
| mem_rdata_o | output | 32 | Read data returned to the data path |
| mem_rvalid_o | output | 1 | Read data valid |
| arr_we_o | output | 1 | Array write strobe |
| arr_re_o | output | 1 | Array read strobe |
| arr_addr_o | output | 16 | Array address |
| arr_be_o | output | 4 | Array byte enables |
| arr_wdata_o | output | 32 | Array write data |
| arr_wpar_o | output | 4 | Array write parity, one bit per lane |
| arr_rdata_i | input | 32 | Array read data, one cycle after `arr_re_o` |
| arr_rpar_i | input | 4 | Array read parity bits |
| arr_rvalid_i | input | 1 | Array read data valid |
| reg_wr_i | input | 1 | Control write strobe (clears the held error) |
| reg_wdata_i | input | 8 | Control write data, bits 6..4 used |
| csr_o | output | 8 | Status byte: 7 pending, 6 irq enable, 5 test, 4 check enable, 3..0 lane flags |
| err_addr_o | output | 16 | Address of the held error |
| irq_o | output | 1 | Error interrupt |

## Verification
The hardest case to reach is a control write that lands in the same cycle as a failing read result. The bench issues a read of a word stored with inverted parity and drives the control write exactly one cycle later, when the array presents the data. This checks that the clear and the new capture resolve in the right order. Lane masking is exercised by corrupting chosen lanes in the bench's array model and reading them with partial byte enables. Stickiness is exercised by a second failing read to a different address while an error is still held.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  typedef struct packed {
    logic ie;
    logic test;
    logic chk;
  } mpg_ctrl_t;
endpackage

// File: rtl/mpg_par_gen.sv
module mpg_par_gen #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic                    invert_i,
  output logic [LANES-1:0]        par_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par_o[g] = (^data_i[g*LANE_W +: LANE_W]) ^ invert_i;
  end
endmodule

// File: rtl/mpg_par_chk.sv
module mpg_par_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic [LANES-1:0]        par_i,
  input  logic [LANES-1:0]        lane_en_i,
  input  logic                    valid_i,
  input  logic                    chk_en_i,
  output logic [LANES-1:0]        lane_err_o
);
  logic [LANES-1:0] calc;

  mpg_par_gen #(.LANES(LANES), .LANE_W(LANE_W)) i_calc (
    .data_i  (data_i),
    .invert_i(1'b0),
    .par_o   (calc)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_err_o[g] = valid_i & chk_en_i & lane_en_i[g] & (calc[g] ^ par_i[g]);
  end
endmodule

// File: rtl/mpg_rd_track.sv
module mpg_rd_track #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);
  // the array answers one cycle after the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      be_o   <= '0;
    end else if (issue_i) begin
      addr_o <= addr_i;
      be_o   <= be_i;
    end
  end
endmodule

// File: rtl/mpg_err_capture.sv
module mpg_err_capture
  import mpg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  mpg_ctrl_t         ctrl_d_i,
  input  logic [LANES-1:0]  lane_err_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  output mpg_ctrl_t         ctrl_o,
  output logic              pend_o,
  output logic [LANES-1:0]  flags_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic new_err, take;

  assign new_err = |lane_err_i;
  // a clear frees the slot in the same cycle
  assign take    = new_err & (clr_i | ~pend_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      pend_o  <= 1'b0;
      flags_o <= '0;
      addr_o  <= '0;
    end else begin
      if (clr_i) begin
        ctrl_o  <= ctrl_d_i;
        pend_o  <= 1'b0;
        flags_o <= '0;
      end
      if (take) begin
        pend_o  <= 1'b1;
        flags_o <= lane_err_i;
        addr_o  <= err_addr_i;
      end
    end
  end
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mem_wr_i,
  input  logic                    mem_rd_i,
  input  logic [ADDR_W-1:0]       mem_addr_i,
  input  logic [LANES-1:0]        mem_be_i,
  input  logic [LANES*LANE_W-1:0] mem_wdata_i,
  output logic [LANES*LANE_W-1:0] mem_rdata_o,
  output logic                    mem_rvalid_o,
  output logic                    arr_we_o,
  output logic                    arr_re_o,
  output logic [ADDR_W-1:0]       arr_addr_o,
  output logic [LANES-1:0]        arr_be_o,
  output logic [LANES*LANE_W-1:0] arr_wdata_o,
  output logic [LANES-1:0]        arr_wpar_o,
  input  logic [LANES*LANE_W-1:0] arr_rdata_i,
  input  logic [LANES-1:0]        arr_rpar_i,
  input  logic                    arr_rvalid_i,
  input  logic                    reg_wr_i,
  input  logic [7:0]              reg_wdata_i,
  output logic [LANES+3:0]        csr_o,
  output logic [ADDR_W-1:0]       err_addr_o,
  output logic                    irq_o
);
  localparam int DATA_W = LANES * LANE_W;

  mpg_ctrl_t         ctrl, ctrl_d;
  logic              pend;
  logic [LANES-1:0]  flags;
  logic [LANES-1:0]  lane_err;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [LANES-1:0]  rd_be_q;
  logic              rd_issue;

  assign rd_issue    = mem_rd_i & ~mem_wr_i;
  assign arr_we_o    = mem_wr_i;
  assign arr_re_o    = rd_issue;
  assign arr_addr_o  = mem_addr_i;
  assign arr_be_o    = mem_be_i;
  assign arr_wdata_o = mem_wdata_i;
  assign mem_rdata_o = arr_rdata_i;
  assign mem_rvalid_o = arr_rvalid_i;

  mpg_par_gen #(.LANES(LANES), .LANE_W(LANE_W)) i_gen (
    .data_i  (mem_wdata_i),
    .invert_i(ctrl.test),
    .par_o   (arr_wpar_o)
  );

  mpg_rd_track #(.LANES(LANES), .ADDR_W(ADDR_W)) i_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(rd_issue),
    .addr_i (mem_addr_i),
    .be_i   (mem_be_i),
    .addr_o (rd_addr_q),
    .be_o   (rd_be_q)
  );

  mpg_par_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_chk (
    .data_i    (arr_rdata_i),
    .par_i     (arr_rpar_i),
    .lane_en_i (rd_be_q),
    .valid_i   (arr_rvalid_i),
    .chk_en_i  (ctrl.chk),
    .lane_err_o(lane_err)
  );

  assign ctrl_d.ie   = reg_wdata_i[6];
  assign ctrl_d.test = reg_wdata_i[5];
  assign ctrl_d.chk  = reg_wdata_i[4];

  mpg_err_capture #(.LANES(LANES), .ADDR_W(ADDR_W)) i_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (reg_wr_i),
    .ctrl_d_i  (ctrl_d),
    .lane_err_i(lane_err),
    .err_addr_i(rd_addr_q),
    .ctrl_o    (ctrl),
    .pend_o    (pend),
    .flags_o   (flags),
    .addr_o    (err_addr_o)
  );

  assign csr_o = {pend, ctrl.ie, ctrl.test, ctrl.chk, flags};
  assign irq_o = pend & ctrl.ie;

  logic unused_ok;
  assign unused_ok = ^{reg_wdata_i[7], reg_wdata_i[3:0], DATA_W[0]};
endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [LANES+3:0]  csr_o,
  input logic [ADDR_W-1:0] err_addr_o,
  input logic              irq_o,
  input logic [LANES-1:0]  lane_err,
  input logic [LANES-1:0]  rd_be_q
);
  localparam int PEND = LANES + 3;
  localparam int IE   = LANES + 2;
  localparam int CHK  = LANES;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[PEND] && !reg_wr_i) |=> ($stable(err_addr_o) && $stable(csr_o[LANES-1:0])));

  p_irq_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (csr_o[PEND] && csr_o[IE]));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && lane_err == '0) |=>
      (!csr_o[PEND] && csr_o[LANES-1:0] == '0 && csr_o[PEND-1:CHK] == $past(reg_wdata_i[6:4])));

  p_nochk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_o[PEND] && !csr_o[CHK] && !reg_wr_i) |=> !csr_o[PEND]);

  p_lane_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csr_o[PEND]) |-> ((csr_o[LANES-1:0] & ~$past(rd_be_q)) == '0));

  p_pend_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[PEND] == (csr_o[LANES-1:0] != '0));

  p_same_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && lane_err != '0) |=> (csr_o[PEND] && csr_o[LANES-1:0] == $past(lane_err)));
endmodule

bind mem_parity_guard mpg_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) i_mpg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .csr_o      (csr_o),
  .err_addr_o (err_addr_o),
  .irq_o      (irq_o),
  .lane_err   (lane_err),
  .rd_be_q    (rd_be_q)
);

// File: tb/test_mem_parity_guard.sv
module test_mem_parity_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_wr_i = 0, mem_rd_i = 0;
  logic [15:0] mem_addr_i = '0;
  logic [3:0]  mem_be_i = '0;
  logic [31:0] mem_wdata_i = '0;
  logic [31:0] mem_rdata_o;
  logic        mem_rvalid_o;
  logic        arr_we_o, arr_re_o;
  logic [15:0] arr_addr_o;
  logic [3:0]  arr_be_o;
  logic [31:0] arr_wdata_o;
  logic [3:0]  arr_wpar_o;
  logic [31:0] arr_rdata_i;
  logic [3:0]  arr_rpar_i;
  logic        arr_rvalid_i;
  logic        reg_wr_i = 0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  csr_o;
  logic [15:0] err_addr_o;
  logic        irq_o;

  always #2.5 clk_i = ~clk_i;

  mem_parity_guard i_mem_parity_guard (.*);

  // array model: one-cycle read latency
  logic [31:0] m_d [16];
  logic [3:0]  m_p [16];
  initial for (int i = 0; i < 16; i++) begin m_d[i] = '0; m_p[i] = '0; end
  always_ff @(posedge clk_i) begin
    arr_rvalid_i <= arr_re_o;
    arr_rdata_i  <= m_d[arr_addr_o[5:2]];
    arr_rpar_i   <= m_p[arr_addr_o[5:2]];
    if (arr_we_o)
      for (int l = 0; l < 4; l++)
        if (arr_be_o[l]) begin
          m_d[arr_addr_o[5:2]][l*8 +: 8] <= arr_wdata_o[l*8 +: 8];
          m_p[arr_addr_o[5:2]][l]        <= arr_wpar_o[l];
        end
  end

  typedef struct {
    string       req;
    logic [7:0]  csr;
    logic [15:0] addr;
    logic        irq;
  } exp_t;
  exp_t sb_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (csr_o !== e.csr || err_addr_o !== e.addr || irq_o !== e.irq) begin
        fails++;
        $display("FAIL %s: csr=%h addr=%h irq=%b expected csr=%h addr=%h irq=%b",
                 e.req, csr_o, err_addr_o, irq_o, e.csr, e.addr, e.irq);
      end
    end
  end

  task automatic expect_st(string req, logic [7:0] c, logic [15:0] a, logic i);
    exp_t e;
    e.req = req; e.csr = c; e.addr = a; e.irq = i;
    sb_q.push_back(e);
    @(negedge clk_i);
    #0.5;
  endtask

  function automatic logic [3:0] even_par(logic [31:0] d);
    logic [3:0] p;
    for (int l = 0; l < 4; l++) p[l] = ^d[l*8 +: 8];
    return p;
  endfunction

  task automatic regw(logic [7:0] v);
    @(posedge clk_i); #1;
    reg_wr_i = 1; reg_wdata_i = v;
    @(posedge clk_i); #1;
    reg_wr_i = 0;
  endtask

  task automatic memw(string req, logic [15:0] a, logic [3:0] be, logic [31:0] d, logic [3:0] exp_par);
    @(posedge clk_i); #1;
    mem_wr_i = 1; mem_addr_i = a; mem_be_i = be; mem_wdata_i = d;
    #0.5;
    checks++;
    if (arr_wpar_o !== exp_par) begin
      fails++;
      $display("FAIL %s: wpar=%b expected %b", req, arr_wpar_o, exp_par);
    end
    @(posedge clk_i); #1;
    mem_wr_i = 0;
  endtask

  // read; optional control write in the data-return cycle
  task automatic memr(logic [15:0] a, logic [3:0] be, bit clr, logic [7:0] v);
    @(posedge clk_i); #1;
    mem_rd_i = 1; mem_addr_i = a; mem_be_i = be;
    @(posedge clk_i); #1;
    mem_rd_i = 0;
    if (clr) begin reg_wr_i = 1; reg_wdata_i = v; end
    @(posedge clk_i); #1;
    reg_wr_i = 0;
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #12 rst_ni = 1;
    expect_st("R10 reset", 8'h00, 16'h0000, 0);

    regw(8'h10);
    expect_st("R7 load check enable", 8'h10, 16'h0000, 0);

    memw("R1 even parity", 16'h0010, 4'hF, 32'hA73C0E81, even_par(32'hA73C0E81));
    memr(16'h0010, 4'hF, 0, 8'h00);
    expect_st("R1 clean read no flag", 8'h10, 16'h0000, 0);

    regw(8'h30);
    memw("R2 inverted parity", 16'h0020, 4'hF, 32'h12345678, ~even_par(32'h12345678));
    regw(8'h10);
    memr(16'h0020, 4'hF, 0, 8'h00);
    expect_st("R3 capture all lanes, R9 irq off", 8'h9F, 16'h0020, 0);

    m_d[4][0] = ~m_d[4][0];
    memr(16'h0010, 4'hF, 0, 8'h00);
    expect_st("R6 sticky first error", 8'h9F, 16'h0020, 0);

    regw(8'h50);
    expect_st("R7 clear keeps address", 8'h50, 16'h0020, 0);
    memr(16'h0010, 4'hF, 0, 8'h00);
    expect_st("R3 lane0 flag, R9 irq on", 8'hD1, 16'h0010, 1);

    regw(8'h40);
    expect_st("R9 irq low after clear", 8'h40, 16'h0010, 0);
    memr(16'h0010, 4'hF, 0, 8'h00);
    expect_st("R4 check disabled", 8'h40, 16'h0010, 0);

    regw(8'h50);
    m_d[4][16] = ~m_d[4][16];
    memr(16'h0010, 4'b1010, 0, 8'h00);
    expect_st("R5 unread lanes ignored", 8'h50, 16'h0010, 0);
    memr(16'h0010, 4'b0100, 0, 8'h00);
    expect_st("R5 only lane2 flagged", 8'hD4, 16'h0010, 1);

    memr(16'h0020, 4'hF, 1, 8'h50);
    expect_st("R8 capture after same-cycle clear", 8'hDF, 16'h0020, 1);

    regw(8'h70);
    memw("R2 inverted parity partial write", 16'h0030, 4'b0001, 32'hFFFFFF55, ~even_par(32'hFFFFFF55));
    regw(8'h50);
    memr(16'h0030, 4'hF, 0, 8'h00);
    expect_st("R2 only written lane fails", 8'hD1, 16'h0030, 1);

    rst_ni = 0;
    #3 rst_ni = 1;
    expect_st("R10 reset after activity", 8'h00, 16'h0000, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule